// File: doc/BRIEF.md
# I2C Target Front End with Four-State Address Straps

This block is the serial front end of a small port expander. It runs from a fast system clock and samples the I2C clock and data lines through synchronizers. It finds START, repeated START and STOP conditions, takes in the address byte and answers only to its own address. On a write it stores each data byte into an 8-bit output port. On a read it shifts out the 8-bit input port. The block only ever pulls SDA low. It never drives SCL.

The upper three address bits are fixed. The lower four come from two strap pins, and each pin carries two of those bits. A strap pin may be tied low, tied high, wired to SDA or wired to SCL. The block tells these four cases apart by watching the pins against the bus lines. The window runs from reset until the first SCL fall that follows the first START. After that the decoded address is frozen until the next reset.

Top module: `i2c_strap_target`

## Requirements
- R1: A falling SDA while SCL is high is a START. It restarts address reception from any state, including the middle of a byte or the middle of a transfer, so no STOP is needed before it. A rising SDA while SCL is high is a STOP, which returns the block to idle.
- R2: The first byte after a START is seven address bits, most significant first, followed by a direction bit (0 = write, 1 = read). When the seven bits equal {1,1,0,A3,A2,A1,A0}, the block holds SDA low for the whole ninth clock.
- R3: When the address does not match, the block does not acknowledge it. It also leaves SDA released, and leaves the output port unchanged, until the next START or STOP.
- R4: Strap codes are: low = 00, high = 01, wired to SDA = 10, wired to SCL = 11. The code of strap_hi_i gives A3:A2 and the code of strap_lo_i gives A1:A0.
- R5: In a write, each data byte (most significant bit first) is acknowledged and copied to port_out_o when its eighth bit is complete. When a write has several bytes, the last one remains on the port.
- R6: In a read, the block presents the value of port_in_i, most significant bit first. It takes a new copy of port_in_i for each byte that the master acknowledges.
- R7: When the master does not acknowledge a read byte, the block stops sending and keeps SDA released until the next START.
- R8: The block's pull on SDA changes only while the synchronized SCL is low.
- R9: After reset, port_out_o is zero and SDA is released.
- R10: The strap classification is frozen at the first SCL fall after the first START following reset. Later changes on the strap pins do not move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad (wired-AND level) |
| strap_hi_i | input | 1 | Strap pin for address bits A3:A2 |
| strap_lo_i | input | 1 | Strap pin for address bits A1:A0 |
| port_in_i | input | DATA_W | Value returned on reads |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| port_out_o | output | DATA_W | Last byte written |

## Verification
The bench steps through a table of strap combinations that covers all four pin states on each pin. For each combination it writes and reads at the address decoded from the straps, then writes at the same address with bit 0 flipped. This separates correct decoding of static pins from correct decoding of bus-wired pins, and a wrong bit pairing shows up as a missing acknowledge. Directed sequences then cover:
- a START that cuts into an address byte;
- a repeated START that turns a write into a read;
- multi-byte writes;
- an all-zero read ended by a NACK, which exposes any SDA pull left behind;
- a wrong fixed prefix;
- strap pins that change after the freeze point.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } bus_st_e;

  localparam logic [2:0] ADDR_PREFIX = 3'b110;

  // Four-state strap decode from what was observed on the pin
  function automatic logic [1:0] strap_code(input logic seen_hi,
                                            input logic seen_lo,
                                            input logic miss_sda);
    if (!seen_hi)       return 2'b00;
    else if (!seen_lo)  return 2'b01;
    else if (!miss_sda) return 2'b10;
    else                return 2'b11;
  endfunction

  function automatic logic [6:0] target_addr(input logic [1:0] hi,
                                             input logic [1:0] lo);
    return {ADDR_PREFIX, hi, lo};
  endfunction

endpackage

// File: rtl/i2c_strap_sync.sv
module i2c_strap_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_strap_cls.sv
module i2c_strap_cls #(
  parameter int PINS  = 2,
  parameter int WARM  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [PINS-1:0]   pin_s,
  input  logic              start_ev,
  input  logic              scl_fall,
  output logic [2*PINS-1:0] codes,
  output logic              locked
);
  import i2c_strap_pkg::*;

  localparam int WW = $clog2(WARM + 1);

  logic [WW-1:0] warm_cnt;
  logic          armed;
  logic          started;
  logic          observe;

  assign armed   = (warm_cnt == WW'(WARM));
  assign observe = armed && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cnt <= '0;
      started  <= 1'b0;
      locked   <= 1'b0;
    end else begin
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
      if (start_ev) started <= 1'b1;
      if (started && scl_fall) locked <= 1'b1;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic seen_hi, seen_lo, miss_sda;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_hi  <= 1'b0;
        seen_lo  <= 1'b0;
        miss_sda <= 1'b0;
      end else if (observe) begin
        if (pin_s[p])          seen_hi  <= 1'b1;
        if (!pin_s[p])         seen_lo  <= 1'b1;
        if (pin_s[p] != sda_s) miss_sda <= 1'b1;
      end
    end
    assign codes[2*p +: 2] = strap_code(seen_hi, seen_lo, miss_sda);
  end

  // scl_s is only referenced through the freeze event; keep it observed
  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/i2c_strap_engine.sv
module i2c_strap_engine #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_s,
  input  logic                  sda_s,
  input  logic [6:0]            dev_addr,
  input  logic [DATA_W-1:0]     port_in,
  output logic                  sda_pull,
  output logic [DATA_W-1:0]     port_out,
  output i2c_strap_pkg::bus_st_e st,
  output logic                  start_ev,
  output logic                  stop_ev,
  output logic                  scl_fall,
  output logic                  wr_done
);
  import i2c_strap_pkg::*;

  localparam int ABITS = 8;
  localparam int CW    = $clog2((DATA_W > ABITS ? DATA_W : ABITS) + 1);

  logic              scl_q, sda_q;
  logic              scl_rise;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] tx;
  logic              rw;
  logic              mnack;

  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign wr_done  = (st == ST_WR) && scl_fall && (cnt == CW'(DATA_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      mnack    <= 1'b0;
      port_out <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_ev) begin
        st  <= ST_ADDR;
        cnt <= '0;
      end else if (stop_ev) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(ABITS)) begin
              if (sh[7:1] == dev_addr) begin
                st <= ST_AACK;
                rw <= sh[0];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st <= ST_RD;
              tx <= port_in;
            end else begin
              st <= ST_WR;
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[DATA_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (wr_done) begin
              st       <= ST_WACK;
              port_out <= sh;
            end
          end
          ST_WACK: if (scl_fall) begin
            st  <= ST_WR;
            cnt <= '0;
          end
          ST_RD: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == CW'(DATA_W)) st <= ST_RACK;
              else tx <= {tx[DATA_W-2:0], 1'b0};
            end
          end
          ST_RACK: begin
            if (scl_rise) mnack <= sda_s;
            else if (scl_fall) begin
              if (!mnack) begin
                st  <= ST_RD;
                tx  <= port_in;
                cnt <= '0;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = (st == ST_AACK) || (st == ST_WACK) ||
                    ((st == ST_RD) && !tx[DATA_W-1]);
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_hi_i,
  input  logic              strap_lo_i,
  input  logic [DATA_W-1:0] port_in_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] port_out_o
);
  import i2c_strap_pkg::*;

  localparam int NPIN = 2;

  logic [NPIN+1:0]   raw, synced;
  logic              scl_s, sda_s;
  logic [NPIN-1:0]   pin_s;
  logic [2*NPIN-1:0] codes;
  logic [1:0]        code_hi, code_lo;
  logic              locked;
  logic [6:0]        dev_addr;
  bus_st_e           st;
  logic              start_ev, stop_ev, scl_fall, wr_done;

  assign raw = {strap_hi_i, strap_lo_i, sda_i, scl_i};

  i2c_strap_sync #(.W(NPIN + 2), .STAGES(SYNC_STAGES), .RST_VAL('1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign scl_s = synced[0];
  assign sda_s = synced[1];
  assign pin_s = synced[NPIN+1:2];   // [1]=hi pin, [0]=lo pin

  i2c_strap_cls #(.PINS(NPIN), .WARM(SYNC_STAGES + 1)) cls_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .pin_s(pin_s),
    .start_ev(start_ev), .scl_fall(scl_fall), .codes(codes), .locked(locked)
  );

  assign code_hi  = codes[3:2];
  assign code_lo  = codes[1:0];
  assign dev_addr = target_addr(code_hi, code_lo);

  i2c_strap_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .dev_addr(dev_addr), .port_in(port_in_i), .sda_pull(sda_pull_o),
    .port_out(port_out_o), .st(st), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_fall(scl_fall), .wr_done(wr_done)
  );
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   sda_pull_o,
  input logic [DATA_W-1:0]      port_out_o,
  input i2c_strap_pkg::bus_st_e st,
  input logic                   start_ev,
  input logic                   stop_ev,
  input logic                   wr_done,
  input logic                   locked,
  input logic [1:0]             code_hi,
  input logic [1:0]             code_lo
);
  import i2c_strap_pkg::*;

  // R8
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR));

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (st == ST_IDLE));

  // R2
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK) |-> sda_pull_o);

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_pull_o);

  // R5
  out_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out_o) |-> $past(wr_done));

  // R10
  strap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(code_hi) && $stable(code_lo)));
endmodule

bind i2c_strap_target i2c_strap_target_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .port_out_o(port_out_o), .st(st), .start_ev(start_ev), .stop_ev(stop_ev),
  .wr_done(wr_done), .locked(locked), .code_hi(code_hi), .code_lo(code_lo)
);

// File: tb/i2c_strap_target_tb_top.sv
`timescale 1ns/1ps
module i2c_strap_target_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] mode_hi = 2'd0, mode_lo = 2'd0;
  logic [7:0] port_in = 8'h00;
  logic       sda_pull;
  logic [7:0] port_out;
  logic       sda_line, scl_line, strap_hi, strap_lo;

  int n_cmp = 0;
  int n_bad = 0;
  int r8_viol = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = m_scl;
  assign sda_line = m_sda & ~sda_pull;
  assign strap_hi = (mode_hi == 2'd0) ? 1'b0 : (mode_hi == 2'd1) ? 1'b1 :
                    (mode_hi == 2'd2) ? sda_line : scl_line;
  assign strap_lo = (mode_lo == 2'd0) ? 1'b0 : (mode_lo == 2'd1) ? 1'b1 :
                    (mode_lo == 2'd2) ? sda_line : scl_line;

  i2c_strap_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .strap_hi_i(strap_hi), .strap_lo_i(strap_lo), .port_in_i(port_in),
    .sda_pull_o(sda_pull), .port_out_o(port_out)
  );

  // R8 monitor: the pull may only move while SCL is low
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_pull !== prev_pull) && m_scl) r8_viol++;
    prev_pull = sda_pull;
  end

  // {strap_hi mode, strap_lo mode, write byte, read byte}
  localparam logic [19:0] VEC [4] = '{
    {2'd0, 2'd1, 8'hA5, 8'h3C},
    {2'd2, 2'd3, 8'h5A, 8'hC3},
    {2'd3, 2'd0, 8'hFF, 8'h00},
    {2'd1, 2'd2, 8'h01, 8'h80}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic q_wait();
    #80;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    #100;
    rst_n = 1'b1;
    #100;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q_wait();
    m_scl = 1'b1; q_wait();
    m_sda = 1'b0; q_wait();
    m_scl = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q_wait();
    m_scl = 1'b1; q_wait();
    m_sda = 1'b1; q_wait();
  endtask

  task automatic send_bit(input logic v);
    m_sda = v; q_wait();
    m_scl = 1'b1; q_wait(); q_wait();
    m_scl = 1'b0; q_wait();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; q_wait();
    m_scl = 1'b1; q_wait();
    ack = ~sda_line;
    q_wait();
    m_scl = 1'b0; q_wait();
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q_wait();
      m_scl = 1'b1; q_wait();
      b[i] = sda_line;
      q_wait();
      m_scl = 1'b0; q_wait();
    end
    send_bit(~give_ack);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    logic [6:0] a;
    #3;
    // Table walk: strap decode, write, read, wrong address
    for (int v = 0; v < 4; v++) begin
      mode_hi = VEC[v][19:18];
      mode_lo = VEC[v][17:16];
      a = {3'b110, VEC[v][19:18], VEC[v][17:16]};
      do_reset();
      bus_start();
      wr_byte({a, 1'b0}, ack);
      chk("R4 strap address acknowledged", 32'(ack), 32'd1);
      wr_byte(VEC[v][15:8], ack);
      chk("R5 data byte acknowledged", 32'(ack), 32'd1);
      bus_stop();
      chk("R5 port_out after write", 32'(port_out), 32'(VEC[v][15:8]));
      port_in = VEC[v][7:0];
      bus_start();
      wr_byte({a, 1'b1}, ack);
      chk("R2 read address acknowledged", 32'(ack), 32'd1);
      rd_byte(b, 1'b0);
      bus_stop();
      chk("R6 read byte", 32'(b), 32'(VEC[v][7:0]));
      bus_start();
      wr_byte({a ^ 7'h01, 1'b0}, ack);
      chk("R3 flipped A0 not acknowledged", 32'(ack), 32'd0);
      wr_byte(~VEC[v][15:8], ack);
      chk("R3 byte after mismatch not acknowledged", 32'(ack), 32'd0);
      bus_stop();
      chk("R3 port_out kept after mismatch", 32'(port_out), 32'(VEC[v][15:8]));
    end

    // Directed: reset state, straps both low -> address 0x60
    mode_hi = 2'd0; mode_lo = 2'd0;
    do_reset();
    chk("R9 port_out after reset", 32'(port_out), 32'd0);
    chk("R9 SDA released after reset", 32'(sda_pull), 32'd0);

    // START cutting into an address byte, then repeated START write->read
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    wr_byte({7'h60, 1'b0}, ack);
    chk("R1 address after mid-byte START", 32'(ack), 32'd1);
    wr_byte(8'h11, ack);
    port_in = 8'h96;
    bus_start();
    wr_byte({7'h60, 1'b1}, ack);
    chk("R1 address after repeated START", 32'(ack), 32'd1);
    rd_byte(b, 1'b0);
    bus_stop();
    chk("R1 read after repeated START", 32'(b), 32'h96);
    chk("R5 write before repeated START", 32'(port_out), 32'h11);

    // Multi-byte write: last byte stays
    bus_start();
    wr_byte({7'h60, 1'b0}, ack);
    wr_byte(8'h12, ack);
    wr_byte(8'h34, ack);
    chk("R5 second byte acknowledged", 32'(ack), 32'd1);
    bus_stop();
    chk("R5 last byte wins", 32'(port_out), 32'h34);

    // Two-byte read of zeros, NACK, then extra clocks must see released SDA
    port_in = 8'h00;
    bus_start();
    wr_byte({7'h60, 1'b1}, ack);
    rd_byte(b, 1'b1);
    chk("R6 first of two read bytes", 32'(b), 32'h00);
    rd_byte(b, 1'b0);
    chk("R6 second read byte", 32'(b), 32'h00);
    rd_byte(b, 1'b0);
    chk("R7 SDA released after master NACK", 32'(b), 32'hFF);
    bus_stop();

    // Wrong fixed prefix
    bus_start();
    wr_byte({7'h20, 1'b0}, ack);
    chk("R3 wrong prefix not acknowledged", 32'(ack), 32'd0);
    bus_stop();

    // Straps changed after freeze: old address must still answer
    mode_hi = 2'd1; mode_lo = 2'd1;
    #200;
    bus_start();
    wr_byte({7'h65, 1'b0}, ack);
    chk("R10 new strap address ignored", 32'(ack), 32'd0);
    bus_stop();
    bus_start();
    wr_byte({7'h60, 1'b0}, ack);
    chk("R10 frozen address still acknowledged", 32'(ack), 32'd1);
    wr_byte(8'h77, ack);
    bus_stop();
    chk("R10 write through frozen address", 32'(port_out), 32'h77);

    chk("R8 pull changed while SCL high", 32'(r8_viol), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule